// File: doc/BRIEF.md
# UART Interrupt and FIFO Trigger Controller

This block collects every interrupt cause of a UART and turns them into interrupt outputs. Eleven sources feed a raw status vector: four modem-line change events, a receive FIFO level trigger, a transmit FIFO level trigger, a receive timeout and four receive error events (framing, parity, break, overrun). A mask register selects the sources that reach the masked status vector. That vector is ORed into a single combined interrupt line. Software clears raw status bits by writing ones to a clear register.

The two FIFO level triggers compare the current fill level with a fraction of the FIFO depth chosen by a 3-bit code. The transmit trigger fires when the level falls to or below the threshold. The receive trigger fires when the level rises to or above it. Each trigger sets its status bit only in the cycle where its condition becomes true. The block also gates the receive DMA request lines. When the block-on-error control is set and any masked error interrupt is active, both receive DMA requests are forced low.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask, the raw status, the masked status, the trigger codes and the DMA control all read 0, and `irq_any_o` is low.
- R2: Transmit trigger code `c` (register 4, bits [2:0]) gives threshold DEPTH/8, DEPTH/4, DEPTH/2, 3·DEPTH/4 or 7·DEPTH/8 for c = 0..4, which is 4, 8, 16, 24 or 28 at DEPTH 32. Raw bit 5 sets when the transmit level changes from above the threshold to at or below it.
- R3: Receive trigger code (register 4, bits [5:3]) uses the same thresholds. Raw bit 4 sets when the receive level changes from below the threshold to at or above it.
- R4: The unused codes 5, 6 and 7 select the DEPTH/2 threshold on both triggers.
- R5: A trigger sets its raw bit only on the cycle its condition becomes true. Holding the level inside the condition after a clear leaves the bit clear.
- R6: A one-cycle pulse on an event input sets exactly its raw bit one clock later. The bit order is: ring 0, CTS 1, DCD 2, DSR 3 (`modem_chg_i[3:0]`), receive 4, transmit 5, timeout 6, framing 7, parity 8, break 9, overrun 10.
- R7: A write to register 0 loads the mask, and a read of register 0 returns it. Register 2 and `irq_vec_o` read raw AND mask.
- R8: Register 1 returns the raw status whatever the mask holds.
- R9: Writing a one to a bit of register 3 clears the matching raw bit. If an event for that bit arrives in the same cycle, the bit stays set. Register 3 reads 0.
- R10: `irq_any_o` is high exactly when some masked status bit is high.
- R11: When register 5 bit 0 is set and any of masked bits 7 to 10 is high, both receive DMA request outputs are low. Otherwise they follow their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level_i | input | LVL_W (6) | Transmit FIFO fill level |
| rx_level_i | input | LVL_W (6) | Receive FIFO fill level |
| modem_chg_i | input | 4 | Modem change pulses: ring, CTS, DCD, DSR in bits 0..3 |
| rx_tmo_i | input | 1 | Receive timeout event |
| frm_err_i | input | 1 | Framing error event |
| par_err_i | input | 1 | Parity error event |
| brk_err_i | input | 1 | Break error event |
| ovr_err_i | input | 1 | Overrun error event |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data |
| rx_dma_single_i | input | 1 | Receive DMA single request from the FIFO side |
| rx_dma_burst_i | input | 1 | Receive DMA burst request from the FIFO side |
| rx_dma_single_o | output | 1 | Gated receive DMA single request |
| rx_dma_burst_o | output | 1 | Gated receive DMA burst request |
| irq_vec_o | output | 11 | Masked status per source |
| irq_any_o | output | 1 | Combined interrupt |

## Verification
A table of trigger vectors steps each FIFO level across every threshold code. Each pair of vectors lands once exactly on the threshold and once one entry away, so an off-by-one or a reversed compare sense shows up as a wrong raw bit. The unused codes are checked on both sides of DEPTH/2 to tell them apart from their neighbouring codes. Directed cases then pulse each event alone to pin the bit order. They also hold a level in its condition to separate edge from level behaviour, and collide a clear with a new event to expose the priority. Masking and DMA gating are exercised with errors both masked and unmasked.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NSRC   = 11;
   localparam int REG_W  = 16;
   localparam int ADDR_W = 3;

   typedef enum logic [3:0] {
      SRC_RING  = 4'd0,
      SRC_CTS   = 4'd1,
      SRC_DCD   = 4'd2,
      SRC_DSR   = 4'd3,
      SRC_RX    = 4'd4,
      SRC_TX    = 4'd5,
      SRC_TMO   = 4'd6,
      SRC_FRM   = 4'd7,
      SRC_PAR   = 4'd8,
      SRC_BRK   = 4'd9,
      SRC_OVR   = 4'd10
   } irq_src_e;

   typedef enum logic [ADDR_W-1:0] {
      RG_MASK   = 3'd0,
      RG_RAW    = 3'd1,
      RG_MSKD   = 3'd2,
      RG_CLR    = 3'd3,
      RG_TRIG   = 3'd4,
      RG_DMACTL = 3'd5
   } reg_idx_e;
endpackage

// File: rtl/irq_level_trigger.sv
module irq_level_trigger #(
   parameter int DEPTH    = 32,
   parameter int LVL_W    = $clog2(DEPTH + 1),
   parameter bit RX_SENSE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level_i,
   input  logic [2:0]       code_i,
   output logic             evt_o
);
   localparam logic [LVL_W-1:0] THR_8TH  = LVL_W'(DEPTH / 8);
   localparam logic [LVL_W-1:0] THR_QTR  = LVL_W'(DEPTH / 4);
   localparam logic [LVL_W-1:0] THR_HALF = LVL_W'(DEPTH / 2);
   localparam logic [LVL_W-1:0] THR_3Q   = LVL_W'((3 * DEPTH) / 4);
   localparam logic [LVL_W-1:0] THR_7E   = LVL_W'((7 * DEPTH) / 8);

   if (DEPTH < 8 || (DEPTH % 8) != 0) begin : g_bad_depth
      $error("irq_level_trigger: DEPTH must be a multiple of 8, at least 8");
   end
   if (LVL_W < $clog2(DEPTH + 1)) begin : g_bad_width
      $error("irq_level_trigger: LVL_W too narrow for DEPTH");
   end

   logic [LVL_W-1:0] thr;
   logic             cond;
   logic             cond_q;

   always_comb begin
      unique case (code_i)
         3'd0:    thr = THR_8TH;
         3'd1:    thr = THR_QTR;
         3'd2:    thr = THR_HALF;
         3'd3:    thr = THR_3Q;
         3'd4:    thr = THR_7E;
         default: thr = THR_HALF;
      endcase
   end

   if (RX_SENSE) begin : g_fill_up
      assign cond = (level_i >= thr);
   end else begin : g_drain_down
      assign cond = (level_i <= thr);
   end

   // history resets to 1 so that leaving reset is not taken as a crossing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b1;
      else        cond_q <= cond;
   end

   assign evt_o = cond & ~cond_q;

   // R5
   single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> !evt_o);
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic         mask_we_i,
   input  logic [N-1:0] mask_wd_i,
   output logic [N-1:0] raw_o,
   output logic [N-1:0] mask_o,
   output logic [N-1:0] masked_o
);
   if (N < 1) begin : g_bad_n
      $error("irq_status_bank: N must be positive");
   end

   logic [N-1:0] raw_q;
   logic [N-1:0] mask_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          raw_q[i] <= 1'b0;
         else if (set_i[i])   raw_q[i] <= 1'b1;
         else if (clr_i[i])   raw_q[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_we_i) mask_q <= mask_wd_i;
   end

   assign raw_o    = raw_q;
   assign mask_o   = mask_q;
   assign masked_o = raw_q & mask_q;

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i)));
   // R9
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~set_i)) |=> ((raw_q & $past(clr_i & ~set_i)) == '0));
   // R6
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_q & ~$past(raw_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  tx_level_i,
   input  logic [LVL_W-1:0]  rx_level_i,
   input  logic [3:0]        modem_chg_i,
   input  logic              rx_tmo_i,
   input  logic              frm_err_i,
   input  logic              par_err_i,
   input  logic              brk_err_i,
   input  logic              ovr_err_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   input  logic              rx_dma_single_i,
   input  logic              rx_dma_burst_i,
   output logic              rx_dma_single_o,
   output logic              rx_dma_burst_o,
   output logic [NSRC-1:0]   irq_vec_o,
   output logic              irq_any_o
);
   localparam int ERR_LO = int'(SRC_FRM);
   localparam int ERR_HI = int'(SRC_OVR);

   if (REG_W < NSRC) begin : g_bad_reg
      $error("uart_irq_ctrl: register width below source count");
   end

   logic [2:0]      tx_code_q;
   logic [2:0]      rx_code_q;
   logic            dma_blk_q;
   logic            tx_evt;
   logic            rx_evt;
   logic [NSRC-1:0] set_vec;
   logic [NSRC-1:0] clr_vec;
   logic [NSRC-1:0] raw;
   logic [NSRC-1:0] mask;
   logic [NSRC-1:0] masked;
   logic            err_active;
   logic            wr_mask;
   logic            wr_clr;
   logic            wr_trig;
   logic            wr_dma;

   assign wr_mask = reg_we_i && (reg_addr_i == RG_MASK);
   assign wr_clr  = reg_we_i && (reg_addr_i == RG_CLR);
   assign wr_trig = reg_we_i && (reg_addr_i == RG_TRIG);
   assign wr_dma  = reg_we_i && (reg_addr_i == RG_DMACTL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_code_q <= '0;
         rx_code_q <= '0;
         dma_blk_q <= 1'b0;
      end else begin
         if (wr_trig) begin
            tx_code_q <= reg_wdata_i[2:0];
            rx_code_q <= reg_wdata_i[5:3];
         end
         if (wr_dma) dma_blk_q <= reg_wdata_i[0];
      end
   end

   irq_level_trigger #(.DEPTH(DEPTH), .LVL_W(LVL_W), .RX_SENSE(1'b0)) u_tx_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (tx_level_i),
      .code_i  (tx_code_q),
      .evt_o   (tx_evt)
   );

   irq_level_trigger #(.DEPTH(DEPTH), .LVL_W(LVL_W), .RX_SENSE(1'b1)) u_rx_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (rx_level_i),
      .code_i  (rx_code_q),
      .evt_o   (rx_evt)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[3:0]     = modem_chg_i;
      set_vec[SRC_RX]  = rx_evt;
      set_vec[SRC_TX]  = tx_evt;
      set_vec[SRC_TMO] = rx_tmo_i;
      set_vec[SRC_FRM] = frm_err_i;
      set_vec[SRC_PAR] = par_err_i;
      set_vec[SRC_BRK] = brk_err_i;
      set_vec[SRC_OVR] = ovr_err_i;
   end

   assign clr_vec = wr_clr ? reg_wdata_i[NSRC-1:0] : '0;

   irq_status_bank #(.N(NSRC)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_vec),
      .clr_i     (clr_vec),
      .mask_we_i (wr_mask),
      .mask_wd_i (reg_wdata_i[NSRC-1:0]),
      .raw_o     (raw),
      .mask_o    (mask),
      .masked_o  (masked)
   );

   assign irq_vec_o  = masked;
   assign irq_any_o  = |masked;
   assign err_active = |masked[ERR_HI:ERR_LO];

   assign rx_dma_single_o = rx_dma_single_i & ~(dma_blk_q & err_active);
   assign rx_dma_burst_o  = rx_dma_burst_i  & ~(dma_blk_q & err_active);

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         RG_MASK:   reg_rdata_o[NSRC-1:0] = mask;
         RG_RAW:    reg_rdata_o[NSRC-1:0] = raw;
         RG_MSKD:   reg_rdata_o[NSRC-1:0] = masked;
         RG_TRIG:   reg_rdata_o[5:0]      = {rx_code_q, tx_code_q};
         RG_DMACTL: reg_rdata_o[0]        = dma_blk_q;
         default:   reg_rdata_o           = '0;
      endcase
   end

   // R11
   dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_blk_q && (|irq_vec_o[ERR_HI:ERR_LO])) |-> (!rx_dma_single_o && !rx_dma_burst_o));
   // R7
   mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_vec_o & ~mask) == '0));
   // R10
   any_follows_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any_o |-> (irq_vec_o != '0));
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 32;
   localparam int LVL_W = 6;
   localparam int NV = 20;

   // {is_rx, code[2:0], from[5:0], to[5:0], expect}
   localparam logic [16:0] VEC [NV] = '{
      {1'b0, 3'd0, 6'd10, 6'd4,  1'b1},
      {1'b0, 3'd0, 6'd10, 6'd5,  1'b0},
      {1'b0, 3'd1, 6'd10, 6'd8,  1'b1},
      {1'b0, 3'd1, 6'd10, 6'd9,  1'b0},
      {1'b0, 3'd2, 6'd20, 6'd16, 1'b1},
      {1'b0, 3'd3, 6'd30, 6'd24, 1'b1},
      {1'b0, 3'd3, 6'd30, 6'd25, 1'b0},
      {1'b0, 3'd4, 6'd31, 6'd28, 1'b1},
      {1'b0, 3'd5, 6'd20, 6'd16, 1'b1},
      {1'b0, 3'd7, 6'd20, 6'd17, 1'b0},
      {1'b1, 3'd0, 6'd0,  6'd4,  1'b1},
      {1'b1, 3'd0, 6'd0,  6'd3,  1'b0},
      {1'b1, 3'd1, 6'd0,  6'd8,  1'b1},
      {1'b1, 3'd2, 6'd0,  6'd16, 1'b1},
      {1'b1, 3'd2, 6'd0,  6'd15, 1'b0},
      {1'b1, 3'd3, 6'd0,  6'd24, 1'b1},
      {1'b1, 3'd4, 6'd0,  6'd28, 1'b1},
      {1'b1, 3'd4, 6'd0,  6'd27, 1'b0},
      {1'b1, 3'd6, 6'd0,  6'd16, 1'b1},
      {1'b1, 3'd5, 6'd0,  6'd15, 1'b0}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [LVL_W-1:0] tx_level = '0;
   logic [LVL_W-1:0] rx_level = '0;
   logic [3:0]       modem_chg = '0;
   logic             rx_tmo = 0, frm_err = 0, par_err = 0, brk_err = 0, ovr_err = 0;
   logic             reg_we = 0;
   logic [2:0]       reg_addr = '0;
   logic [15:0]      reg_wdata = '0;
   logic [15:0]      reg_rdata;
   logic             dma_s_in = 1'b1, dma_b_in = 1'b1;
   logic             dma_s_out, dma_b_out;
   logic [10:0]      irq_vec;
   logic             irq_any;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_irq_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .tx_level_i(tx_level), .rx_level_i(rx_level),
      .modem_chg_i(modem_chg), .rx_tmo_i(rx_tmo), .frm_err_i(frm_err),
      .par_err_i(par_err), .brk_err_i(brk_err), .ovr_err_i(ovr_err),
      .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .rx_dma_single_i(dma_s_in), .rx_dma_burst_i(dma_b_in),
      .rx_dma_single_o(dma_s_out), .rx_dma_burst_o(dma_b_out),
      .irq_vec_o(irq_vec), .irq_any_o(irq_any)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse_src(input int idx);
      @(negedge clk);
      case (idx)
         0, 1, 2, 3: modem_chg[idx] = 1'b1;
         6:  rx_tmo  = 1'b1;
         7:  frm_err = 1'b1;
         8:  par_err = 1'b1;
         9:  brk_err = 1'b1;
         default: ovr_err = 1'b1;
      endcase
      @(negedge clk);
      modem_chg = '0; rx_tmo = 0; frm_err = 0; par_err = 0; brk_err = 0; ovr_err = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(3'd0, d); chk("R1 mask", d, 16'h0);
      rd(3'd1, d); chk("R1 raw", d, 16'h0);
      rd(3'd4, d); chk("R1 codes", d, 16'h0);
      chk("R1 irq_any", {15'b0, irq_any}, 16'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      rd(3'd1, d); chk("R1 raw after release", d, 16'h0);

      // R2 R3 R4 trigger table
      for (int i = 0; i < NV; i++) begin
         logic        is_rx;
         logic [2:0]  code;
         logic [5:0]  lf, lt;
         logic        ex;
         {is_rx, code, lf, lt, ex} = VEC[i];
         @(negedge clk);
         if (is_rx) rx_level = lf; else tx_level = lf;
         wr(3'd4, is_rx ? {10'b0, code, 3'b0} : {13'b0, code});
         @(negedge clk);
         wr(3'd3, 16'h07FF);
         if (is_rx) rx_level = lt; else tx_level = lt;
         @(negedge clk);
         rd(3'd1, d);
         chk(is_rx ? "R3/R4 rx trigger" : "R2/R4 tx trigger",
             {15'b0, is_rx ? d[4] : d[5]}, {15'b0, ex});
         @(negedge clk);
         tx_level = '0; rx_level = '0;
         @(negedge clk);
      end

      // R5 holding inside the condition does not re-set
      wr(3'd4, 16'h0010);
      rx_level = 6'd20;
      @(negedge clk);
      wr(3'd3, 16'h07FF);
      repeat (3) @(negedge clk);
      rd(3'd1, d); chk("R5 rx level held", {15'b0, d[4]}, 16'h0);
      rx_level = '0;
      @(negedge clk);
      wr(3'd3, 16'h07FF);

      // R6 each event sets exactly its bit
      foreach (VEC[k]) begin end
      for (int s = 0; s < 11; s++) begin
         if (s == 4 || s == 5) continue;
         pulse_src(s);
         rd(3'd1, d); chk("R6 source bit", d, 16'(1 << s));
         wr(3'd3, 16'h07FF);
      end

      // R7 R8 R10 masking
      wr(3'd0, 16'h00A5);
      rd(3'd0, d); chk("R7 mask readback", d, 16'h00A5);
      pulse_src(8);
      rd(3'd1, d); chk("R8 raw ignores mask", d, 16'h0100);
      rd(3'd2, d); chk("R7 masked reg", d, 16'h0);
      chk("R10 any low when masked off", {15'b0, irq_any}, 16'h0);
      wr(3'd0, 16'h01A5);
      rd(3'd2, d); chk("R7 masked reg on", d, 16'h0100);
      chk("R7 irq_vec", {5'b0, irq_vec}, 16'h0100);
      chk("R10 any high", {15'b0, irq_any}, 16'h1);

      // R9 clear and collision with a new event
      wr(3'd3, 16'h0100);
      rd(3'd1, d); chk("R9 clear", d, 16'h0);
      chk("R10 any after clear", {15'b0, irq_any}, 16'h0);
      @(negedge clk);
      par_err = 1'b1; reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h0100;
      @(negedge clk);
      par_err = 1'b0; reg_we = 1'b0;
      rd(3'd1, d); chk("R9 set wins", d, 16'h0100);
      rd(3'd3, d); chk("R9 clear reads zero", d, 16'h0);

      // R11 DMA gating
      chk("R11 pass without control", {14'b0, dma_s_out, dma_b_out}, 16'h3);
      wr(3'd5, 16'h0001);
      chk("R11 blocked", {14'b0, dma_s_out, dma_b_out}, 16'h0);
      wr(3'd0, 16'h0000);
      chk("R11 pass when error masked", {14'b0, dma_s_out, dma_b_out}, 16'h3);
      wr(3'd0, 16'h0100);
      wr(3'd3, 16'h0100);
      chk("R11 pass after clear", {14'b0, dma_s_out, dma_b_out}, 16'h3);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule